// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array with Output Macrocells

This block is a soft model of a small field-configurable logic device. A programmable AND plane forms product terms from eight external pins and four feedback lines. Each product term can use any of these signals in true form, in inverted form, or not at all. Each of the four outputs ORs its own dedicated group of four product terms. That grouping is fixed, and no term is ever shared between outputs. Every output then passes through a macrocell. The macrocell can invert the sum, and it selects either the combinational value or a flip-flop that captures that value on each rising clock edge.

Registered outputs feed their flip-flop value back into the AND plane, so a single configuration can describe a small state machine. A combinational output feeds back only into outputs with a higher index. This gives an ordered expander chain: a function that needs more than four terms is built by consuming one output inside another. The configuration is a single shift chain. It is loaded one bit per clock while the synchronous reset is held. The same reset clears every output flip-flop.

Top module: `plogic_array`

## Requirements
- R1: A product term is the AND of its connected literals. Literal indices 0..7 are `pin_in[0..7]` and indices 8..11 are the feedback of outputs 0..3. Term t of output o occupies configuration bits starting at (o*4+t)*24. Within that field, bit 2l connects literal l in true form and bit 2l+1 connects it in inverted form.
- R2: A product term with no connected literal evaluates to 0.
- R3: A product term that connects both forms of the same literal evaluates to 0.
- R4: Output o ORs only its own four terms, so a term programmed in one output's group never affects another output.
- R5: Configuration bit 384+2o inverts the sum of output o when set.
- R6: Configuration bit 385+2o selects registered mode for output o. In that mode `pin_out[o]` shows a flip-flop that loads the polarity-adjusted sum at every rising edge. When the bit is clear, `pin_out[o]` shows the polarity-adjusted sum combinationally.
- R7: The feedback literal of a registered output is its flip-flop value. The feedback literal of a combinational output k carries its polarity-adjusted value into outputs with an index above k. It reads as 0 in output k itself and in every output with an index below k.
- R8: At a rising edge with `rst` and `cfg_shift_en` both high, the 392-bit chain shifts one place toward bit 0 and `cfg_bit` enters at bit 391. After 392 such edges, the first bit sent sits at bit 0.
- R9: `cfg_shift_en` has no effect at an edge where `rst` is low.
- R10: At a rising edge with `rst` high, every output flip-flop is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; it also opens the configuration chain |
| cfg_shift_en | input | 1 | Shifts the configuration chain while in reset |
| cfg_bit | input | 1 | Serial configuration data |
| pin_in | input | 8 | External input literals |
| pin_out | output | 4 | Macrocell outputs |

## Verification
Two events can fall in the same cycle: a shift request on the configuration chain, and a registered state advance through feedback. The bench provokes this overlap by holding `cfg_shift_en` high with changing `cfg_bit` values while a programmed 2-bit counter and its glue logic run out of reset. It also provokes the pairing of reset with a pending next-state value. A behavioural model that ignores the shift request and forces state to zero under reset is compared against `pin_out` on every cycle. Any corrupted configuration, or any missed clear, therefore shows up as a miscompare in the counter or glue outputs.

// File: rtl/plogic_pkg.sv
`timescale 1ns/1ps
package plogic_pkg;
  parameter int N_IN  = 8;
  parameter int N_OUT = 4;
  parameter int N_PT  = 4;

  localparam int N_LIT  = N_IN + N_OUT;
  localparam int TERM_W = 2 * N_LIT;
  localparam int N_TERM = N_OUT * N_PT;
  localparam int AND_W  = N_TERM * TERM_W;
  localparam int MC_W   = 2 * N_OUT;
  localparam int CFG_W  = AND_W + MC_W;

  // AND of connected literals; no connection at all yields 0.
  function automatic logic term_eval(input logic [TERM_W-1:0] tcfg,
                                     input logic [N_LIT-1:0]  lits);
    logic hit_any;
    logic hit_all;
    hit_any = 1'b0;
    hit_all = 1'b1;
    for (int l = 0; l < N_LIT; l++) begin
      if (tcfg[2*l]) begin
        hit_any = 1'b1;
        if (!lits[l]) hit_all = 1'b0;
      end
      if (tcfg[2*l+1]) begin
        hit_any = 1'b1;
        if (lits[l]) hit_all = 1'b0;
      end
    end
    return hit_any & hit_all;
  endfunction

  // True when some literal is wired in both forms.
  function automatic logic term_conflict(input logic [TERM_W-1:0] tcfg);
    logic c;
    c = 1'b0;
    for (int l = 0; l < N_LIT; l++)
      if (tcfg[2*l] && tcfg[2*l+1]) c = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/plogic_cfg_chain.sv
`timescale 1ns/1ps
module plogic_cfg_chain
  import plogic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [CFG_W-1:0] cfg
);
  logic shift_now;
  assign shift_now = rst & shift_en;

  always_ff @(posedge clk) begin
    if (shift_now) cfg <= {bit_in, cfg[CFG_W-1:1]};
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(cfg)) else $error("configuration moved outside reset"); // R9
endmodule

// File: rtl/plogic_plane.sv
`timescale 1ns/1ps
module plogic_plane
  import plogic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [AND_W-1:0]  and_cfg,
  input  logic [N_OUT-1:0]  inv_sel,
  input  logic [N_OUT-1:0]  reg_sel,
  input  logic [N_IN-1:0]   pin_in,
  input  logic [N_OUT-1:0]  q,
  output logic [N_OUT-1:0]  d,
  output logic [N_TERM-1:0] term_hit
);
  logic [N_OUT-1:0] fb;
  logic [N_OUT-1:0] sum;

  // Outputs are resolved in index order; a combinational result becomes
  // visible as feedback only to later outputs, which keeps the netlist acyclic.
  always_comb begin
    fb       = q & reg_sel;
    term_hit = '0;
    sum      = '0;
    d        = '0;
    for (int o = 0; o < N_OUT; o++) begin
      for (int t = 0; t < N_PT; t++)
        term_hit[o*N_PT+t] = term_eval(and_cfg[(o*N_PT+t)*TERM_W +: TERM_W], {fb, pin_in});
      sum[o] = |term_hit[o*N_PT +: N_PT];
      d[o]   = sum[o] ^ inv_sel[o];
      if (!reg_sel[o]) fb[o] = d[o];
    end
  end

  for (genvar i = 0; i < N_TERM; i++) begin : g_term_chk
    AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (rst)
      (and_cfg[i*TERM_W +: TERM_W] == '0) |-> !term_hit[i]) else $error("empty term high"); // R2
    AST_CONFLICT_TERM: assert property (@(posedge clk) disable iff (rst)
      term_conflict(and_cfg[i*TERM_W +: TERM_W]) |-> !term_hit[i]) else $error("conflict term high"); // R3
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_grp_chk
    AST_FIXED_GROUP: assert property (@(posedge clk) disable iff (rst)
      (term_hit[o*N_PT +: N_PT] == '0) |-> (d[o] == inv_sel[o])) else $error("sum without own term"); // R4
  end
endmodule

// File: rtl/plogic_regs.sv
`timescale 1ns/1ps
module plogic_regs
  import plogic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] d,
  output logic [N_OUT-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (q == '0)) else $error("flip-flops not cleared"); // R10
endmodule

// File: rtl/plogic_array.sv
`timescale 1ns/1ps
module plogic_array
  import plogic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shift_en,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_OUT-1:0] pin_out
);
  logic [CFG_W-1:0]  cfg;
  logic [AND_W-1:0]  and_cfg;
  logic [N_OUT-1:0]  inv_sel;
  logic [N_OUT-1:0]  reg_sel;
  logic [N_OUT-1:0]  d;
  logic [N_OUT-1:0]  q;
  logic [N_TERM-1:0] term_hit;

  plogic_cfg_chain u_cfg (
    .clk(clk), .rst(rst), .shift_en(cfg_shift_en), .bit_in(cfg_bit), .cfg(cfg)
  );

  assign and_cfg = cfg[AND_W-1:0];

  for (genvar o = 0; o < N_OUT; o++) begin : g_mc
    assign inv_sel[o] = cfg[AND_W + 2*o];
    assign reg_sel[o] = cfg[AND_W + 2*o + 1];
  end

  plogic_plane u_plane (
    .clk(clk), .rst(rst), .and_cfg(and_cfg), .inv_sel(inv_sel), .reg_sel(reg_sel),
    .pin_in(pin_in), .q(q), .d(d), .term_hit(term_hit)
  );

  plogic_regs u_regs (
    .clk(clk), .rst(rst), .d(d), .q(q)
  );

  assign pin_out = (reg_sel & q) | (~reg_sel & d);

  AST_REG_PIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    reg_sel[0] |=> (pin_out[0] == $past(d[0]))) else $error("registered pin missed capture"); // R6
endmodule

// File: tb/test_plogic_array.sv
`timescale 1ns/1ps
module test_plogic_array;
  localparam int NI = 8, NO = 4, NP = 4, NL = 12, TW = 24, AW = 384, CW = 392;

  logic clk = 1'b0, rst = 1'b1, cfg_shift_en = 1'b0, cfg_bit = 1'b0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] pin_out;

  plogic_array i_plogic_array (
    .clk(clk), .rst(rst), .cfg_shift_en(cfg_shift_en), .cfg_bit(cfg_bit),
    .pin_in(pin_in), .pin_out(pin_out)
  );

  always #4 clk = ~clk;

  logic [NL-1:0] m_true [NO][NP];
  logic [NL-1:0] m_comp [NO][NP];
  logic [NO-1:0] inv, regm, ref_q;
  int n_vec = 0, n_bad = 0;
  int lfsr = 32'h1ace;

  task automatic clear_masks();
    for (int o = 0; o < NO; o++) begin
      for (int t = 0; t < NP; t++) begin
        m_true[o][t] = '0; m_comp[o][t] = '0;
      end
    end
    inv = '0; regm = '0;
  endtask

  function automatic logic [CW-1:0] image();
    logic [CW-1:0] v;
    v = '0;
    for (int o = 0; o < NO; o++) begin
      for (int t = 0; t < NP; t++) begin
        for (int l = 0; l < NL; l++) begin
          v[(o*NP+t)*TW + 2*l]     = m_true[o][t][l];
          v[(o*NP+t)*TW + 2*l + 1] = m_comp[o][t][l];
        end
      end
      v[AW + 2*o]     = inv[o];
      v[AW + 2*o + 1] = regm[o];
    end
    return v;
  endfunction

  // Behavioural model: pins shown and next flip-flop values.
  task automatic model(input logic [NI-1:0] v, output logic [NO-1:0] shown,
                       output logic [NO-1:0] nxt);
    logic [NO-1:0] fbv;
    logic [NL-1:0] lits;
    logic s;
    fbv = ref_q & regm;
    for (int o = 0; o < NO; o++) begin
      s = 1'b0;
      lits = {fbv, v};
      for (int t = 0; t < NP; t++) begin
        if ((m_true[o][t] | m_comp[o][t]) != 0 &&
            (lits & m_true[o][t]) == m_true[o][t] &&
            (~lits & m_comp[o][t]) == m_comp[o][t]) s = 1'b1;
      end
      nxt[o] = s ^ inv[o];
      if (!regm[o]) fbv[o] = nxt[o];
      shown[o] = regm[o] ? ref_q[o] : nxt[o];
    end
  endtask

  task automatic cycle(input logic [NI-1:0] v, input logic r, input logic sh,
                       input logic b, input string tag);
    logic [NO-1:0] ev, dv;
    @(negedge clk);
    pin_in = v; rst = r; cfg_shift_en = sh; cfg_bit = b;
    #1;
    model(v, ev, dv);
    n_vec++;
    if (pin_out !== ev) begin
      n_bad++;
      $display("FAIL %s: pin_in=%h pin_out=%b expected=%b", tag, v, pin_out, ev);
    end
    @(posedge clk);
    ref_q = r ? '0 : dv;
  endtask

  // R8: serial load, bit 0 first, under reset.
  task automatic load(input logic [CW-1:0] img);
    for (int i = 0; i < CW; i++) begin
      @(negedge clk); rst = 1'b1; cfg_shift_en = 1'b1; cfg_bit = img[i];
    end
    @(negedge clk); cfg_shift_en = 1'b0;
    @(posedge clk); ref_q = '0;
  endtask

  function automatic logic [NL-1:0] lit(input int idx);
    logic [NL-1:0] m;
    m = '0; m[idx] = 1'b1;
    return m;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    summary();
  end

  initial begin
    // Configuration A: gated 2-bit counter plus glue through the expander chain.
    clear_masks();
    regm[0] = 1'b1;                                  // R6 registered
    m_true[0][0] = lit(8);  m_comp[0][0] = lit(0);   // q0 & ~in0
    m_comp[0][1] = lit(8);  m_true[0][1] = lit(0);   // ~q0 & in0
    regm[1] = 1'b1;
    m_true[1][0] = lit(9);  m_comp[1][0] = lit(8);
    m_true[1][1] = lit(9);  m_comp[1][1] = lit(0);
    m_comp[1][2] = lit(9);  m_true[1][2] = lit(8) | lit(0);
    m_true[2][0] = lit(1) | lit(2);                  // R1 R4 glue
    m_true[2][1] = lit(3);  m_comp[2][1] = lit(4);
    m_true[2][2] = lit(5);
    inv[3] = 1'b1;                                   // R5
    m_true[3][0] = lit(10) | lit(6);                 // R7 comb feedback from output 2
    m_true[3][1] = lit(7) | lit(9);                  // R7 registered feedback
    m_true[3][2] = lit(11);                          // R7 self feedback reads 0
    load(image());
    for (int k = 0; k < 3; k++) cycle(8'h00, 1'b1, 1'b0, 1'b0, "R10 reset state A");
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 256; v++)
        cycle(v[7:0], 1'b0, 1'b0, 1'b0, "R1 R4 R5 R6 R7 counter and glue");
    end
    for (int k = 0; k < 20; k++) cycle(8'h01, 1'b0, 1'b0, 1'b0, "R6 counter run");
    // R9: shift requests while running must leave the function intact.
    for (int k = 0; k < 200; k++) begin
      lfsr = (lfsr << 1) ^ ((lfsr >>> 31) & 1 ? 32'h04c11db7 : 0);
      cycle(lfsr[7:0], 1'b0, 1'b1, lfsr[9], "R9 shift ignored outside reset");
    end
    for (int v = 0; v < 256; v++)
      cycle(v[7:0], 1'b0, 1'b0, 1'b0, "R9 function after shift attempts");
    // R10: reset mid-count then resume.
    cycle(8'h01, 1'b1, 1'b0, 1'b0, "R10 reset mid-run");
    cycle(8'h01, 1'b1, 1'b0, 1'b0, "R10 reset holds zero");
    for (int k = 0; k < 8; k++) cycle(8'h01, 1'b0, 1'b0, 1'b0, "R10 resume from zero");

    // Configuration B: empty and contradictory terms, registered chain.
    clear_masks();
    inv[0] = 1'b1;                                   // R2 empty group inverted -> 1
    inv[1] = 1'b1; regm[1] = 1'b1;                   // R2 registered -> 1 after reset
    m_true[2][0] = lit(0);  m_comp[2][0] = lit(0);   // R3
    m_true[2][1] = lit(1) | lit(2); m_comp[2][1] = lit(1);
    regm[3] = 1'b1; m_true[3][0] = lit(9);           // R7 q3 follows q1
    load(image());
    for (int k = 0; k < 2; k++) cycle(8'hff, 1'b1, 1'b0, 1'b0, "R10 reset state B");
    for (int v = 0; v < 256; v++)
      cycle(v[7:0], 1'b0, 1'b0, 1'b0, "R2 R3 R7 empty and conflict terms");
    summary();
  end
endmodule